// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller whose pin count is a multiple of 32. Software reaches it through a 32-bit register bus and can drive each pin's output value and output enable, pick one of four alternate functions per pin, and watch the synchronised pad levels. Every pad input passes through a two-stage synchroniser. A per-pin rising or falling transition, when enabled, is latched in a sticky status bit. All status bits are ORed into one interrupt line.

Registers are grouped by function. Each single-bit group spans as many 32-bit words as there are banks of 32 pins (NREG = NUM_PINS/32). Pin n lives at bit n%32 of word n/32 in its group. The alternate-function group packs two bits per pin, so it takes twice as many words. The request side of the bus is a valid-qualified command with no back-pressure: the block accepts a request in every cycle that `req_valid` is high. A read returns its data one cycle later, flagged by `rsp_valid`. The receiver has no way to stall the response, so it must take the data in that cycle.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Group k occupies byte offsets k*NREG*4 to k*NREG*4+NREG*4-1, with word r at k*NREG*4 + r*4. The groups are numbered 0 pad level, 1 output enable, 2 set-output, 3 clear-output, 4 rise enable, 5 fall enable, 6 edge status and 7 alternate function. Group 7 is 2*NREG words long. Reads at any other offset, or at an offset whose two low bits are not zero, return zero and change nothing.
- R2: The pad-level words are read-only. Each bit returns the pad input as seen after two clock stages. Writes to these words have no effect.
- R3: In the output-enable words, a 1 in bit n%32 asserts `pad_oe[n]` (output) and a 0 clears it (input). These words read back as written.
- R4: A write to a set-output word drives `pad_out` high for every bit written as 1. A write to a clear-output word drives `pad_out` low for every bit written as 1. Bits written as 0 leave the output unchanged. Both groups read as zero.
- R5: When rise enable is set for a pin, a 0-to-1 change of its synchronised level sets that pin's status bit on the third rising clock edge after the pad changes. A 1-to-0 change does not set it unless fall enable is also set.
- R6: When fall enable is set, a 1-to-0 change sets the status bit. When both enables are set, either change sets it.
- R7: Writing 1 to an edge-status bit clears it. Writing 0 leaves it unchanged.
- R8: If an enabled edge and a write-1 clear of the same status bit occur in the same cycle, the bit remains set.
- R9: `irq` is high exactly while at least one status bit is set.
- R10: Pin n's alternate-function field is bits (n%16)*2+1 to (n%16)*2 of word n/16 in group 7. It appears on `alt_fn[2n+1:2n]` and reads back as written.
- R11: After reset, output enables, outputs, rise and fall enables, edge status and alternate functions are all zero, and `irq` is low.
- R12: `rsp_valid` is high in the cycle after a read request and low after any cycle that held no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Output values to the pads |
| pad_oe | output | NUM_PINS | Output enables, 1 = drive |
| alt_fn | output | 2*NUM_PINS | Alternate-function select, two bits per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
A detected edge and a software write-1 clear of the same status bit can land in the same cycle. The bench provokes this in two steps. First it latches the status bit of a rise-enabled pin and lowers the pad. It then raises the pad again and places the clear write on the bus exactly two clock edges later, so the clear is sampled on the same edge that records the new edge. A later read of the status word must still show the bit set. A second clear with no edge present must then read back zero, which shows that the kept bit came from the new edge and not from a clear that failed.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W = 32;
  localparam int NUM_GROUPS = 8;

  typedef enum logic [3:0] {
    GRP_LEVEL = 4'd0,
    GRP_OE    = 4'd1,
    GRP_SET   = 4'd2,
    GRP_CLR   = 4'd3,
    GRP_RISE  = 4'd4,
    GRP_FALL  = 4'd5,
    GRP_STAT  = 4'd6,
    GRP_ALT   = 4'd7,
    GRP_NONE  = 4'd15
  } grp_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int NREG   = 2,
  parameter int ADDR_W = 10,
  localparam int IDX_W = (2 * NREG > 1) ? $clog2(2 * NREG) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output grp_e              grp,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-3:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    grp = GRP_NONE;
    idx = '0;
    if (addr[1:0] == 2'b00) begin
      for (int k = 0; k < NUM_GROUPS; k++) begin
        if (int'(word) >= k * NREG &&
            int'(word) < k * NREG + ((k == NUM_GROUPS - 1) ? 2 * NREG : NREG)) begin
          grp = grp_e'(k);
          idx = IDX_W'(int'(word) - k * NREG);
        end
      end
    end
  end
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] lvl_prev
);
  logic [N-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      lvl      <= '0;
      lvl_prev <= '0;
    end else begin
      meta_q   <= pad_in;
      lvl      <= meta_q;
      lvl_prev <= lvl;
    end
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int NREG = 2,
  localparam int N = NREG * WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] lvl_prev,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] edge_hit,
  output logic [N-1:0] status
);
  assign edge_hit = (rise_en & lvl & ~lvl_prev) | (fall_en & ~lvl & lvl_prev);

  for (genvar w = 0; w < NREG; w++) begin : g_word
    logic [WORD_W-1:0] st_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= (st_q & ~clr_mask[w*WORD_W +: WORD_W])
                          | edge_hit[w*WORD_W +: WORD_W];
    end
    assign status[w*WORD_W +: WORD_W] = st_q;
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NREG = 2,
  localparam int N = NREG * WORD_W,
  localparam int IDX_W = (2 * NREG > 1) ? $clog2(2 * NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  grp_e              grp,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [N-1:0]      oe,
  output logic [N-1:0]      out,
  output logic [N-1:0]      rise_en,
  output logic [N-1:0]      fall_en,
  output logic [2*N-1:0]    alt,
  output logic [N-1:0]      clr_mask
);
  for (genvar w = 0; w < NREG; w++) begin : g_word
    logic hit_oe, hit_set, hit_clr, hit_rise, hit_fall, hit_stat;
    logic [WORD_W-1:0] oe_q, out_q, rise_q, fall_q;

    assign hit_oe   = wr_en && grp == GRP_OE   && int'(idx) == w;
    assign hit_set  = wr_en && grp == GRP_SET  && int'(idx) == w;
    assign hit_clr  = wr_en && grp == GRP_CLR  && int'(idx) == w;
    assign hit_rise = wr_en && grp == GRP_RISE && int'(idx) == w;
    assign hit_fall = wr_en && grp == GRP_FALL && int'(idx) == w;
    assign hit_stat = wr_en && grp == GRP_STAT && int'(idx) == w;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oe_q   <= '0;
        out_q  <= '0;
        rise_q <= '0;
        fall_q <= '0;
      end else begin
        if (hit_oe)   oe_q   <= wdata;
        if (hit_set)  out_q  <= out_q | wdata;
        if (hit_clr)  out_q  <= out_q & ~wdata;
        if (hit_rise) rise_q <= wdata;
        if (hit_fall) fall_q <= wdata;
      end
    end

    assign oe[w*WORD_W +: WORD_W]       = oe_q;
    assign out[w*WORD_W +: WORD_W]      = out_q;
    assign rise_en[w*WORD_W +: WORD_W]  = rise_q;
    assign fall_en[w*WORD_W +: WORD_W]  = fall_q;
    assign clr_mask[w*WORD_W +: WORD_W] = hit_stat ? wdata : '0;
  end

  for (genvar j = 0; j < 2 * NREG; j++) begin : g_alt
    logic [WORD_W-1:0] alt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alt_q <= '0;
      else if (wr_en && grp == GRP_ALT && int'(idx) == j) alt_q <= wdata;
    end
    assign alt[j*WORD_W +: WORD_W] = alt_q;
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_data,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [2*NUM_PINS-1:0] alt_fn,
  output logic                  irq
);
  localparam int NREG  = NUM_PINS / WORD_W;
  localparam int IDX_W = (2 * NREG > 1) ? $clog2(2 * NREG) : 1;

  grp_e               grp;
  logic [IDX_W-1:0]   idx;
  logic [NUM_PINS-1:0] lvl, lvl_prev, rise_en, fall_en, clr_mask, edge_hit, stat_q;
  logic [WORD_W-1:0]  rd_mux;

  gpio_addr_decode #(.NREG(NREG), .ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .grp(grp), .idx(idx)
  );

  gpio_pad_sync #(.N(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .lvl(lvl), .lvl_prev(lvl_prev)
  );

  gpio_bank_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(req_valid && req_write), .grp(grp), .idx(idx), .wdata(req_wdata),
    .oe(pad_oe), .out(pad_out), .rise_en(rise_en), .fall_en(fall_en),
    .alt(alt_fn), .clr_mask(clr_mask)
  );

  gpio_edge_bank #(.NREG(NREG)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .lvl_prev(lvl_prev),
    .rise_en(rise_en), .fall_en(fall_en), .clr_mask(clr_mask),
    .edge_hit(edge_hit), .status(stat_q)
  );

  assign irq = |stat_q;

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NREG; w++) begin
      if (int'(idx) == w) begin
        case (grp)
          GRP_LEVEL: rd_mux = lvl[w*WORD_W +: WORD_W];
          GRP_OE:    rd_mux = pad_oe[w*WORD_W +: WORD_W];
          GRP_RISE:  rd_mux = rise_en[w*WORD_W +: WORD_W];
          GRP_FALL:  rd_mux = fall_en[w*WORD_W +: WORD_W];
          GRP_STAT:  rd_mux = stat_q[w*WORD_W +: WORD_W];
          default:   ;
        endcase
      end
    end
    for (int j = 0; j < 2 * NREG; j++) begin
      if (grp == GRP_ALT && int'(idx) == j) rd_mux = alt_fn[j*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                rsp_valid,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic                irq,
  input logic [NUM_PINS-1:0] status_q,
  input logic [NUM_PINS-1:0] edge_hit
);
  localparam int GB = (NUM_PINS / 32) * 4;
  logic wr_oe, wr_out, wr_stat, aligned;

  assign aligned = req_addr[1:0] == 2'b00;
  assign wr_oe   = req_valid && req_write && aligned &&
                   int'(req_addr) >= GB && int'(req_addr) < 2 * GB;
  assign wr_out  = req_valid && req_write && aligned &&
                   int'(req_addr) >= 2 * GB && int'(req_addr) < 4 * GB;
  assign wr_stat = req_valid && req_write && aligned &&
                   int'(req_addr) >= 6 * GB && int'(req_addr) < 7 * GB;

  // R12
  a_r12_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r12_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  // R3
  a_r3_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_oe |=> $stable(pad_oe));
  // R4
  a_r4_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_out |=> $stable(pad_out));
  // R8
  a_r8_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((status_q & $past(edge_hit)) == $past(edge_hit)));
  // R9
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_stat) |=> irq);
  // R11
  a_r11_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!irq && pad_oe == '0 && pad_out == '0));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .pad_oe(pad_oe), .pad_out(pad_out),
  .irq(irq), .status_q(stat_q), .edge_hit(edge_hit)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
  localparam int NP = 64;
  localparam int AW = 10;
  localparam int NR = NP / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_data;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic [2*NP-1:0] alt_fn;
  logic          irq;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_fn(alt_fn), .irq(irq)
  );

  function automatic int fa(int k, int r);
    return k * NR * 4 + r * 4;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R11 irq", 64'(irq), 0);
    chk("R11 oe", pad_oe, 0);
    chk("R11 out", pad_out, 0);
    chk("R11 alt", alt_fn[63:0] | alt_fn[127:64], 0);
    rd(fa(4, 1), d); chk("R11 rise", 64'(d), 0);
    rd(fa(5, 0), d); chk("R11 fall", 64'(d), 0);
    rd(fa(6, 1), d); chk("R11 status", 64'(d), 0);
  endtask

  task automatic t_oe();
    logic [31:0] d;
    wr(fa(1, 1), 32'h8000_0011);
    chk("R3 oe pins", pad_oe, 64'h8000_0011_0000_0000);
    rd(fa(1, 1), d); chk("R1 R3 oe readback", 64'(d), 64'h8000_0011);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(fa(2, 0), 32'h0000_00F0);
    chk("R4 set", pad_out, 64'hF0);
    wr(fa(3, 0), 32'h0000_0030);
    chk("R4 clear", pad_out, 64'hC0);
    wr(fa(2, 0), 32'h0);
    chk("R4 zeros ignored", pad_out, 64'hC0);
    wr(fa(2, 1), 32'h1);
    chk("R4 set word1", pad_out, 64'h1_0000_00C0);
    rd(fa(2, 0), d); chk("R4 set reads zero", 64'(d), 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk) pad_in = 64'hA5A5_0000_1234_5678;
    @(negedge clk);
    rd(fa(0, 0), d); chk("R2 level word0", 64'(d), 64'h1234_5678);
    wr(fa(0, 1), 32'hFFFF_FFFF);
    rd(fa(0, 1), d); chk("R2 level word1 write ignored", 64'(d), 64'hA5A5_0000);
    @(negedge clk) pad_in = '0;
    settle();
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(fa(4, 1), 32'h8);            // pin 35
    @(negedge clk) pad_in[35] = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R5 R9 irq not yet", 64'(irq), 0);
    @(negedge clk); chk("R5 R9 irq on third edge", 64'(irq), 1);
    rd(fa(6, 1), d); chk("R5 status pin35", 64'(d), 64'h8);
    wr(fa(6, 1), 32'h8);
    rd(fa(6, 1), d); chk("R7 cleared", 64'(d), 0);
    chk("R9 irq low", 64'(irq), 0);
    @(negedge clk) pad_in[35] = 1'b0;
    settle(); chk("R5 fall ignored", 64'(irq), 0);
  endtask

  task automatic t_fall_both();
    logic [31:0] d;
    wr(fa(5, 0), 32'h8);            // pin 3 fall only
    @(negedge clk) pad_in[3] = 1'b1;
    settle();
    rd(fa(6, 0), d); chk("R6 rise ignored on fall pin", 64'(d), 0);
    @(negedge clk) pad_in[3] = 1'b0;
    settle();
    rd(fa(6, 0), d); chk("R6 fall latched", 64'(d), 64'h8);
    wr(fa(6, 0), 32'h0);
    rd(fa(6, 0), d); chk("R7 zero write keeps", 64'(d), 64'h8);
    wr(fa(6, 0), 32'h8);
    chk("R9 irq after clear", 64'(irq), 0);
    wr(fa(4, 1), 32'h108);          // pin 40 both, pin 35 rise
    wr(fa(5, 1), 32'h100);
    @(negedge clk) pad_in[40] = 1'b1;
    settle();
    rd(fa(6, 1), d); chk("R6 both rise", 64'(d), 64'h100);
    wr(fa(6, 1), 32'h100);
    @(negedge clk) pad_in[40] = 1'b0;
    settle();
    rd(fa(6, 1), d); chk("R6 both fall", 64'(d), 64'h100);
    wr(fa(6, 1), 32'h100);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk) pad_in[35] = 1'b1;
    settle();
    @(negedge clk) pad_in[35] = 1'b0;
    settle();
    @(negedge clk) pad_in[35] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(fa(6, 1)); req_wdata = 32'h8;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd(fa(6, 1), d); chk("R8 edge kept on clear", 64'(d), 64'h8);
    chk("R8 R9 irq held", 64'(irq), 1);
    wr(fa(6, 1), 32'h8);
    rd(fa(6, 1), d); chk("R8 plain clear", 64'(d), 0);
    @(negedge clk) pad_in[35] = 1'b0;
    settle();
  endtask

  task automatic t_alt();
    logic [31:0] d;
    wr(fa(7, 1), 32'h0000_0008);    // pin 17 field at bits 3:2 = 2
    chk("R10 alt pin17", 64'(alt_fn[35:34]), 2);
    wr(fa(7, 3), 32'hC000_0000);    // pin 63 = 3
    chk("R10 alt pin63", 64'(alt_fn[127:126]), 3);
    rd(fa(7, 1), d); chk("R10 alt readback", 64'(d), 64'h8);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(fa(7, 4), d); chk("R1 unmapped zero", 64'(d), 0);
    chk("R12 rsp_valid", 64'(rsp_valid), 1);
    rd(fa(1, 1) + 2, d); chk("R1 misaligned zero", 64'(d), 0);
    @(negedge clk); chk("R12 rsp idle", 64'(rsp_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oe();
    t_setclr();
    t_level();
    t_rise();
    t_fall_both();
    t_collide();
    t_alt();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule